// File: doc/BRIEF.md
# Register Renamer with Undo History

This block renames destination registers for a single instruction stream. The architectural register space is split into three classes: integer, floating point and miscellaneous. Each class has its own mapping table, indexed by a class-relative register number. Every accepted rename takes a physical register from a shared free pool. It then writes a record to an ordered history: the sequence number, a unified architectural index (class base plus relative index), the new physical register and the physical register it displaced. A per-physical-register ready bit is cleared on allocation and set again by a writeback port. A separate source port returns the current mapping and its ready bit.

Misspeculation and retirement both walk the history, one record per clock. A squash pops records from the young end and restores the old mappings. A commit pops records from the old end and frees the displaced registers. Some registers are never really renamed: integer register 0 and every miscellaneous register. For these the record carries new equal to previous, and both walks leave them untouched. Neither walk may restore their map entry or free their register.

Top module: `reg_rename`

## Requirements
- R1: After reset, integer register i maps to physical i, floating-point register j maps to physical NUM_INT+j, and miscellaneous register k maps to physical NUM_INT+NUM_FP+k. Physical registers from NUM_INT+NUM_FP+NUM_MISC upward are free. Every ready bit is set, busy_o is low and ren_ready_o is high.
- R2: A rename of an ordinary register is accepted when ren_valid_i and ren_ready_o are both high. In that same cycle, ren_new_o is the lowest-numbered free physical register and ren_prev_o is the current mapping. From the next cycle on, the register maps to ren_new_o.
- R3: An accepted ordinary rename clears the ready bit of ren_new_o. A writeback (wb_valid_i) sets the ready bit of wb_phys_i. src_rdy_o reports the ready bit of src_phys_o.
- R4: A rename of integer register 0, or of any miscellaneous register, returns ren_new_o equal to ren_prev_o equal to the current mapping. It allocates nothing and changes neither the map nor the ready bits. It still adds a history record.
- R5: A squash (squash_i with bound S) undoes every history record whose sequence number is greater than S, youngest first. It restores the previous mapping and returns the new register to the free pool.
- R6: The squash walk removes records whose new register equals their previous register, without touching the map or the free pool.
- R7: A commit (commit_i with bound C) removes every record whose sequence number is at most C, oldest first, and returns its previous register to the free pool.
- R8: The commit walk never frees the previous register of a record whose new register equals its previous register.
- R9: A walk handles one record per cycle. busy_o rises the cycle after the request and stays high for k+1 cycles for a walk of k records. If squash_i and commit_i arrive together, the squash wins and the commit is dropped. Requests made while busy_o is high are ignored.
- R10: ren_ready_o is low in any of these cases: busy_o is high, squash_i or commit_i is high, the history holds HB_DEPTH records, or the rename is ordinary and no physical register is free.
- R11: int_lookups_o counts the cycles in which src_valid_i is high with an integer class. fp_lookups_o does the same for the floating-point class. Miscellaneous lookups are not counted.
- R12: Class code 0 selects integer, code 1 selects floating point, and codes 2 and 3 select miscellaneous. The source port reads the same tables as the rename port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 1 | Rename request |
| ren_cls_i | input | 2 | Destination class code |
| ren_idx_i | input | REL_W | Class-relative destination index |
| ren_seq_i | input | SEQ_W | Sequence number of the renaming instruction |
| ren_ready_o | output | 1 | Rename can be accepted this cycle |
| ren_new_o | output | PW | Physical register assigned |
| ren_prev_o | output | PW | Physical register displaced |
| src_valid_i | input | 1 | Source lookup strobe (counted) |
| src_cls_i | input | 2 | Source class code |
| src_idx_i | input | REL_W | Class-relative source index |
| src_phys_o | output | PW | Mapped physical register |
| src_rdy_o | output | 1 | Ready bit of src_phys_o |
| wb_valid_i | input | 1 | Writeback strobe |
| wb_phys_i | input | PW | Physical register written back |
| squash_i | input | 1 | Start a squash walk |
| squash_seq_i | input | SEQ_W | Squash bound: records above it are undone |
| commit_i | input | 1 | Start a commit walk |
| commit_seq_i | input | SEQ_W | Commit bound: records at or below it retire |
| busy_o | output | 1 | A walk is in progress |
| int_lookups_o | output | CNT_W | Integer source lookups |
| fp_lookups_o | output | CNT_W | Floating-point source lookups |

## Verification
The hardest case to reach is a walk that meets self-mapped records mixed in with real ones. Only there does a wrong restore or a wrong free show up. Even then it appears only later, as the wrong register chosen at the next allocation. The stimulus puts renames of integer register 0 and of both miscellaneous codes between real renames, then squashes and commits across them. Because allocation always takes the lowest free register, a leaked physical 0, 16 or 17 would be handed out at once. The stimulus also fills the free pool and then the history, to reach both stall causes in turn.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_FP   = 2'd1,
    CLS_MISC = 2'd2
  } reg_cls_e;

  typedef enum logic [1:0] {
    WALK_IDLE   = 2'd0,
    WALK_SQUASH = 2'd1,
    WALK_COMMIT = 2'd2
  } walk_e;
endpackage

// File: rtl/rr_class_map.sv
module rr_class_map #(
  parameter int N     = 8,
  parameter int PW    = 5,
  parameter int PBASE = 0,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] rd_a_idx_i,
  output logic [PW-1:0] rd_a_o,
  input  logic [IW-1:0] rd_b_idx_i,
  output logic [PW-1:0] rd_b_o,
  input  logic          we_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [PW-1:0] wr_data_i
);
  logic [PW-1:0] map_q [N];

  assign rd_a_o = map_q[rd_a_idx_i];
  assign rd_b_o = map_q[rd_b_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) map_q[i] <= PW'(PBASE + i);
    end else if (we_i) begin
      map_q[wr_idx_i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/rr_free_pool.sv
module rr_free_pool #(
  parameter int NP         = 32,
  parameter int FIRST_FREE = 18,
  parameter int PW         = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  output logic [PW-1:0] alloc_phys_o,
  output logic          empty_o,
  input  logic          rel_i,
  input  logic [PW-1:0] rel_phys_i
);
  logic [NP-1:0] free_q;

  // lowest-numbered free register wins
  always_comb begin
    logic found;
    found        = 1'b0;
    alloc_phys_o = '0;
    for (int i = 0; i < NP; i++) begin
      if (free_q[i] && !found) begin
        alloc_phys_o = PW'(i);
        found        = 1'b1;
      end
    end
  end

  assign empty_o = ~|free_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NP; i++) free_q[i] <= (i >= FIRST_FREE);
    end else begin
      if (alloc_i) free_q[alloc_phys_o] <= 1'b0;
      if (rel_i)   free_q[rel_phys_i]   <= 1'b1;
    end
  end

  assert_no_double_free_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i |-> !free_q[rel_phys_i]);
  assert_alloc_nonempty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !empty_o);
  assert_alloc_rel_apart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_i && rel_i));
endmodule

// File: rtl/rr_hist_buf.sv
module rr_hist_buf #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_head_i,
  input  logic         pop_tail_i,
  output logic [W-1:0] head_o,
  output logic [W-1:0] tail_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q, wr_last, wr_next, rd_next;
  logic [CW-1:0] cnt_q;

  assign wr_last = (wr_q == '0) ? AW'(DEPTH - 1) : wr_q - AW'(1);
  assign wr_next = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
  assign rd_next = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
  assign head_o  = mem_q[rd_q];
  assign tail_o  = mem_q[wr_last];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (push_i) begin
      wr_q  <= wr_next;
      cnt_q <= cnt_q + CW'(1);
    end else if (pop_head_i) begin
      rd_q  <= rd_next;
      cnt_q <= cnt_q - CW'(1);
    end else if (pop_tail_i) begin
      wr_q  <= wr_last;
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assert_push_not_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_pop_not_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_head_i || pop_tail_i) |-> !empty_o);
  assert_single_op_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({push_i, pop_head_i, pop_tail_i}));
  assert_count_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CW'(1)
              || cnt_q + CW'(1) == $past(cnt_q)));
endmodule

// File: rtl/reg_rename.sv
module reg_rename
  import rr_pkg::*;
#(
  parameter int NUM_INT  = 8,
  parameter int NUM_FP   = 8,
  parameter int NUM_MISC = 2,
  parameter int NUM_PHYS = 32,
  parameter int HB_DEPTH = 16,
  parameter int SEQ_W    = 8,
  parameter int CNT_W    = 16,
  localparam int NUM_ARCH  = NUM_INT + NUM_FP + NUM_MISC,
  localparam int FP_BASE   = NUM_INT,
  localparam int MISC_BASE = NUM_INT + NUM_FP,
  localparam int UW        = $clog2(NUM_ARCH),
  localparam int PW        = $clog2(NUM_PHYS),
  localparam int MAX_CLS   = (NUM_INT > NUM_FP) ? ((NUM_INT > NUM_MISC) ? NUM_INT : NUM_MISC)
                                                : ((NUM_FP > NUM_MISC) ? NUM_FP : NUM_MISC),
  localparam int REL_W     = (MAX_CLS > 1) ? $clog2(MAX_CLS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ren_valid_i,
  input  logic [1:0]       ren_cls_i,
  input  logic [REL_W-1:0] ren_idx_i,
  input  logic [SEQ_W-1:0] ren_seq_i,
  output logic             ren_ready_o,
  output logic [PW-1:0]    ren_new_o,
  output logic [PW-1:0]    ren_prev_o,
  input  logic             src_valid_i,
  input  logic [1:0]       src_cls_i,
  input  logic [REL_W-1:0] src_idx_i,
  output logic [PW-1:0]    src_phys_o,
  output logic             src_rdy_o,
  input  logic             wb_valid_i,
  input  logic [PW-1:0]    wb_phys_i,
  input  logic             squash_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  input  logic             commit_i,
  input  logic [SEQ_W-1:0] commit_seq_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] int_lookups_o,
  output logic [CNT_W-1:0] fp_lookups_o
);
  typedef struct packed {
    logic [SEQ_W-1:0] seq;
    logic [UW-1:0]    uidx;
    logic [PW-1:0]    nw;
    logic [PW-1:0]    pv;
  } hist_t;

  function automatic int cls_n(int c);
    case (c)
      0:       return NUM_INT;
      1:       return NUM_FP;
      default: return NUM_MISC;
    endcase
  endfunction

  function automatic int cls_base(int c);
    case (c)
      0:       return 0;
      1:       return FP_BASE;
      default: return MISC_BASE;
    endcase
  endfunction

  function automatic logic [1:0] cls_sel(logic [1:0] code);
    return code[1] ? 2'(CLS_MISC) : {1'b0, code[0]};
  endfunction

  logic [1:0]       ren_sel, src_sel, undo_sel;
  logic             ren_special, alloc, do_rename;
  logic [PW-1:0]    alloc_phys;
  logic             fl_empty, fl_rel;
  logic [PW-1:0]    fl_rel_phys;
  logic [UW-1:0]    ren_uidx;
  hist_t            push_rec, head, tail;
  logic             hb_empty, hb_full;
  walk_e            state_q;
  logic [SEQ_W-1:0] bound_q;
  logic             undo_go, retire_go, undo_wr;
  logic [REL_W-1:0] undo_rel, wr_idx;
  logic [PW-1:0]    wr_data;
  logic [2:0]       map_we;
  logic [PW-1:0]    src_map [3];
  logic [PW-1:0]    dst_map [3];
  logic [NUM_PHYS-1:0] sb_q;

  assign ren_sel     = cls_sel(ren_cls_i);
  assign src_sel     = cls_sel(src_cls_i);
  assign ren_special = (ren_sel == 2'(CLS_MISC)) || (ren_sel == 2'(CLS_INT) && ren_idx_i == '0);

  for (genvar c = 0; c < 3; c++) begin : g_cls
    localparam int CN  = cls_n(c);
    localparam int CIW = (CN > 1) ? $clog2(CN) : 1;
    rr_class_map #(.N(CN), .PW(PW), .PBASE(cls_base(c))) i_map (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_a_idx_i (src_idx_i[CIW-1:0]),
      .rd_a_o     (src_map[c]),
      .rd_b_idx_i (ren_idx_i[CIW-1:0]),
      .rd_b_o     (dst_map[c]),
      .we_i       (map_we[c]),
      .wr_idx_i   (wr_idx[CIW-1:0]),
      .wr_data_i  (wr_data)
    );
  end

  assign ren_prev_o  = dst_map[ren_sel];
  assign ren_new_o   = ren_special ? ren_prev_o : alloc_phys;
  assign ren_ready_o = (state_q == WALK_IDLE) && !squash_i && !commit_i && !hb_full
                       && (ren_special || !fl_empty);
  assign do_rename   = ren_valid_i && ren_ready_o;
  assign alloc       = do_rename && !ren_special;
  assign ren_uidx    = UW'(cls_base(int'(ren_sel))) + UW'(ren_idx_i);

  assign src_phys_o = src_map[src_sel];
  assign src_rdy_o  = sb_q[src_phys_o];

  // history walk
  assign undo_go   = (state_q == WALK_SQUASH) && !hb_empty && (tail.seq > bound_q);
  assign retire_go = (state_q == WALK_COMMIT) && !hb_empty && (head.seq <= bound_q);
  assign undo_wr   = undo_go && (tail.nw != tail.pv);
  assign busy_o    = (state_q != WALK_IDLE);

  always_comb begin
    undo_sel = 2'(CLS_MISC);
    undo_rel = REL_W'(tail.uidx - UW'(MISC_BASE));
    if (int'(tail.uidx) < FP_BASE) begin
      undo_sel = 2'(CLS_INT);
      undo_rel = REL_W'(tail.uidx);
    end else if (int'(tail.uidx) < MISC_BASE) begin
      undo_sel = 2'(CLS_FP);
      undo_rel = REL_W'(tail.uidx - UW'(FP_BASE));
    end
  end

  always_comb begin
    map_we  = '0;
    wr_idx  = ren_idx_i;
    wr_data = alloc_phys;
    if (undo_wr) begin
      map_we[undo_sel] = 1'b1;
      wr_idx           = undo_rel;
      wr_data          = tail.pv;
    end else if (alloc) begin
      map_we[ren_sel] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WALK_IDLE;
      bound_q <= '0;
    end else begin
      case (state_q)
        WALK_IDLE: begin
          if (squash_i) begin
            state_q <= WALK_SQUASH;
            bound_q <= squash_seq_i;
          end else if (commit_i) begin
            state_q <= WALK_COMMIT;
            bound_q <= commit_seq_i;
          end
        end
        WALK_SQUASH: if (!undo_go) state_q <= WALK_IDLE;
        WALK_COMMIT: if (!retire_go) state_q <= WALK_IDLE;
        default:     state_q <= WALK_IDLE;
      endcase
    end
  end

  assign fl_rel      = undo_wr || (retire_go && head.nw != head.pv);
  assign fl_rel_phys = undo_go ? tail.nw : head.pv;

  rr_free_pool #(.NP(NUM_PHYS), .FIRST_FREE(NUM_ARCH), .PW(PW)) i_pool (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_i      (alloc),
    .alloc_phys_o (alloc_phys),
    .empty_o      (fl_empty),
    .rel_i        (fl_rel),
    .rel_phys_i   (fl_rel_phys)
  );

  assign push_rec = '{seq: ren_seq_i, uidx: ren_uidx, nw: ren_new_o, pv: ren_prev_o};

  rr_hist_buf #(.DEPTH(HB_DEPTH), .W($bits(hist_t))) i_hist (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (do_rename),
    .push_data_i (push_rec),
    .pop_head_i  (retire_go),
    .pop_tail_i  (undo_go),
    .head_o      (head),
    .tail_o      (tail),
    .empty_o     (hb_empty),
    .full_o      (hb_full)
  );

  // scoreboard: allocation clear overrides a same-cycle writeback
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sb_q <= '1;
    end else begin
      if (wb_valid_i) sb_q[wb_phys_i] <= 1'b1;
      if (alloc)      sb_q[alloc_phys] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_lookups_o <= '0;
      fp_lookups_o  <= '0;
    end else if (src_valid_i) begin
      if (src_sel == 2'(CLS_INT)) int_lookups_o <= int_lookups_o + CNT_W'(1);
      if (src_sel == 2'(CLS_FP))  fp_lookups_o  <= fp_lookups_o + CNT_W'(1);
    end
  end

  assert_alloc_not_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && ren_ready_o && ren_new_o != ren_prev_o) |=> !sb_q[$past(ren_new_o)]);
  assert_special_self_map_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && ren_ready_o && ren_cls_i[1]) |-> (ren_new_o == ren_prev_o));
  assert_retire_real_int_fp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_go && head.nw != head.pv) |-> (int'(head.uidx) < MISC_BASE));
  assert_busy_blocks_rename_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(squash_i || commit_i) && busy_o |-> !ren_ready_o);
endmodule

// File: tb/test_reg_rename.sv
module test_reg_rename;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 8, NF = 8, NM = 2, NP = 32, HBD = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ren_valid = 0, src_valid = 0, wb_valid = 0, squash = 0, commit = 0;
  logic [1:0] ren_cls = 0, src_cls = 0;
  logic [2:0] ren_idx = 0, src_idx = 0;
  logic [7:0] ren_seq = 0, squash_seq = 0, commit_seq = 0;
  logic [4:0] wb_phys = 0;
  logic       ren_ready, src_rdy, busy;
  logic [4:0] ren_new, ren_prev, src_phys;
  logic [15:0] int_lk, fp_lk;

  always #(CLK_PERIOD / 2) clk = ~clk;

  reg_rename i_reg_rename (
    .clk_i(clk), .rst_ni(rst_n),
    .ren_valid_i(ren_valid), .ren_cls_i(ren_cls), .ren_idx_i(ren_idx), .ren_seq_i(ren_seq),
    .ren_ready_o(ren_ready), .ren_new_o(ren_new), .ren_prev_o(ren_prev),
    .src_valid_i(src_valid), .src_cls_i(src_cls), .src_idx_i(src_idx),
    .src_phys_o(src_phys), .src_rdy_o(src_rdy),
    .wb_valid_i(wb_valid), .wb_phys_i(wb_phys),
    .squash_i(squash), .squash_seq_i(squash_seq),
    .commit_i(commit), .commit_seq_i(commit_seq),
    .busy_o(busy), .int_lookups_o(int_lk), .fp_lookups_o(fp_lk)
  );

  typedef struct {int seq; int u; int nw; int pv;} hrec_t;

  int    compared = 0, mismatched = 0;
  int    m_map [NI+NF+NM];
  bit    m_free [NP];
  bit    m_sb [NP];
  hrec_t hist [$];
  int    m_state = 0, m_bound = 0, m_icnt = 0, m_fcnt = 0;
  int    seq = 1;

  function automatic int sel(logic [1:0] c);
    return c[1] ? 2 : int'(c);
  endfunction
  function automatic int base(int s);
    return (s == 0) ? 0 : (s == 1) ? NI : NI + NF;
  endfunction
  function automatic int lowest_free();
    for (int i = 0; i < NP; i++) if (m_free[i]) return i;
    return -1;
  endfunction
  function automatic bit is_special();
    int s = sel(ren_cls);
    return (s == 2) || (s == 0 && ren_idx == 0);
  endfunction
  function automatic bit exp_ready();
    return m_state == 0 && !squash && !commit && hist.size() < HBD
           && (is_special() || lowest_free() >= 0);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int su = base(sel(src_cls)) + int'(src_idx);
    int ru = base(sel(ren_cls)) + int'(ren_idx);
    chk("R10", "ren_ready", int'(ren_ready), int'(exp_ready()));
    chk("R9", "busy", int'(busy), int'(m_state != 0));
    chk("R12", "src_phys", int'(src_phys), m_map[su]);
    chk("R3", "src_rdy", int'(src_rdy), int'(m_sb[m_map[su]]));
    chk("R11", "int_lookups", int'(int_lk), m_icnt);
    chk("R11", "fp_lookups", int'(fp_lk), m_fcnt);
    if (ren_valid && exp_ready()) begin
      if (is_special()) begin
        chk("R4", "ren_new", int'(ren_new), m_map[ru]);
        chk("R4", "ren_prev", int'(ren_prev), m_map[ru]);
      end else begin
        chk("R2", "ren_new", int'(ren_new), lowest_free());
        chk("R2", "ren_prev", int'(ren_prev), m_map[ru]);
      end
    end
  endtask

  task automatic update_model();
    hrec_t r;
    bit rdy = exp_ready();
    if (wb_valid) m_sb[wb_phys] = 1'b1;
    if (src_valid) begin
      if (sel(src_cls) == 0) m_icnt++;
      if (sel(src_cls) == 1) m_fcnt++;
    end
    case (m_state)
      0: begin
        if (squash) begin m_state = 1; m_bound = int'(squash_seq); end
        else if (commit) begin m_state = 2; m_bound = int'(commit_seq); end
        else if (ren_valid && rdy) begin
          r.u = base(sel(ren_cls)) + int'(ren_idx);
          r.seq = int'(ren_seq);
          r.pv = m_map[r.u];
          if (is_special()) r.nw = r.pv;
          else begin
            r.nw = lowest_free();
            m_map[r.u] = r.nw;
            m_free[r.nw] = 1'b0;
            m_sb[r.nw] = 1'b0;
          end
          hist.push_back(r);
        end
      end
      1: begin
        if (hist.size() > 0 && hist[$].seq > m_bound) begin
          r = hist.pop_back();
          if (r.nw != r.pv) begin m_map[r.u] = r.pv; m_free[r.nw] = 1'b1; end
        end else m_state = 0;
      end
      default: begin
        if (hist.size() > 0 && hist[0].seq <= m_bound) begin
          r = hist.pop_front();
          if (r.nw != r.pv) m_free[r.pv] = 1'b1;
        end else m_state = 0;
      end
    endcase
  endtask

  task automatic tick();
    #1 compare_all();
    @(posedge clk);
    update_model();
    @(negedge clk);
  endtask

  task automatic do_ren(input logic [1:0] c, input logic [2:0] i);
    ren_valid = 1; ren_cls = c; ren_idx = i; ren_seq = 8'(seq); seq++;
    tick();
    ren_valid = 0;
  endtask

  task automatic ren_expect(input logic [1:0] c, input logic [2:0] i, input int exp, input string req);
    ren_valid = 1; ren_cls = c; ren_idx = i; ren_seq = 8'(seq); seq++;
    #1 chk(req, "ren_new", int'(ren_new), exp);
    tick();
    ren_valid = 0;
  endtask

  task automatic look(input logic [1:0] c, input logic [2:0] i, input int exp, input string req);
    src_valid = 1; src_cls = c; src_idx = i;
    #1 chk(req, "src_phys", int'(src_phys), exp);
    tick();
    src_valid = 0;
  endtask

  task automatic walk(input bit is_sq, input int bound, output int nbusy);
    nbusy = 0;
    if (is_sq) begin squash = 1; squash_seq = 8'(bound); end
    else begin commit = 1; commit_seq = 8'(bound); end
    tick();
    squash = 0; commit = 0;
    for (int g = 0; g < 64 && m_state != 0; g++) begin
      if (busy) nbusy++;
      tick();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int nb;
    for (int i = 0; i < NI + NF + NM; i++) m_map[i] = i;
    for (int i = 0; i < NP; i++) begin m_free[i] = (i >= NI + NF + NM); m_sb[i] = 1'b1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset identity
    for (int i = 0; i < NI; i++) look(2'd0, 3'(i), i, "R1");
    for (int i = 0; i < NF; i++) look(2'd1, 3'(i), NI + i, "R1");
    look(2'd2, 3'd1, NI + NF + 1, "R1");
    look(2'd3, 3'd0, NI + NF, "R1");

    ren_expect(2'd0, 3'd3, 18, "R2");
    ren_expect(2'd1, 3'd2, 19, "R2");
    src_valid = 1; src_cls = 0; src_idx = 3;
    #1 chk("R3", "src_rdy after alloc", int'(src_rdy), 0);
    tick(); src_valid = 0;
    wb_valid = 1; wb_phys = 5'd18; tick(); wb_valid = 0;
    src_valid = 1; src_cls = 0; src_idx = 3;
    #1 chk("R3", "src_rdy after wb", int'(src_rdy), 1);
    tick(); src_valid = 0;

    ren_expect(2'd0, 3'd0, 0, "R4");
    ren_expect(2'd2, 3'd1, 17, "R4");
    ren_expect(2'd3, 3'd0, 16, "R4");
    ren_expect(2'd0, 3'd3, 20, "R2");
    ren_expect(2'd1, 3'd2, 21, "R2");

    // squash over two real and two self-mapped records
    walk(1'b1, 3, nb);
    chk("R9", "squash busy cycles", nb, 5);
    look(2'd0, 3'd3, 18, "R5");
    look(2'd1, 3'd2, 19, "R5");
    look(2'd2, 3'd1, 17, "R6");
    ren_expect(2'd0, 3'd4, 20, "R6");

    walk(1'b0, 3, nb);
    chk("R9", "commit busy cycles", nb, 4);
    ren_expect(2'd0, 3'd6, 3, "R7");
    ren_expect(2'd0, 3'd7, 10, "R8");

    // simultaneous requests, then a commit while busy
    squash = 1; commit = 1; squash_seq = 8'd200; commit_seq = 8'd200;
    tick();
    squash = 0;
    commit_seq = 8'd200;
    #1 chk("R9", "busy after joint request", int'(busy), 1);
    tick();
    commit = 0;
    for (int g = 0; g < 8 && m_state != 0; g++) tick();
    walk(1'b1, 7, nb);
    look(2'd0, 3'd7, 7, "R9");
    look(2'd0, 3'd4, 4, "R9");

    // drain the free pool
    for (int k = 0; k < 14; k++)
      do_ren((k % 2 == 0) ? 2'd0 : 2'd1, (k % 2 == 0) ? 3'(1 + (k / 2) % 7) : 3'((k / 2) % 8));
    ren_valid = 1; ren_cls = 0; ren_idx = 3'd2;
    #1 chk("R10", "ready with empty pool", int'(ren_ready), 0);
    tick(); ren_valid = 0;
    do_ren(2'd2, 3'd0);
    do_ren(2'd3, 3'd1);
    ren_valid = 1; ren_cls = 2'd2; ren_idx = 3'd0;
    #1 chk("R10", "ready with full history", int'(ren_ready), 0);
    tick(); ren_valid = 0;

    walk(1'b0, 255, nb);
    chk("R7", "commit of full history busy", nb, 17);
    src_valid = 1; src_cls = 2'd2; src_idx = 0; tick();
    src_cls = 2'd1; tick(); src_valid = 0;
    chk("R11", "fp lookups total", int'(fp_lk), m_fcnt);
    ren_expect(2'd1, 3'd5, lowest_free(), "R2");
    repeat (3) tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule